// File: doc/BRIEF.md
# Clock-Mode Control Register with Write-Once Locks

This block is the primary control byte of an on-chip clock generator. Software writes it through a plain write-enable/data port and reads it back at any time. The block drives the static settings that the oscillator and the frequency-locked loop need: gain choice, frequency range, reference type, the clock mode that was asked for, the clock mode actually in force, and the loop prescale factor that follows from the range.

Three settings (gain, range, reference type) lock after the first write that follows reset. The clock-mode field has sequencing rules. A new mode is taken only when no earlier change is still in flight. The bypass-with-external-reference mode is held pending until the external reference reports ready. If the very first write after reset picks a mode that uses no external pin, every later request for an external mode is refused until the next reset. A hold input stands for an off state. It freezes mode completion and leaves the stored field as it was.

Top module: `clkmode_ctl`

## Requirements
- R1: After reset the read data is 0x44 (range bit 6 and stop-enable bit 2 set, all else 0). The effective mode is 00, the block is not busy, and the prescale output is 64.
- R2: Bits 7 (gain), 6 (range) and 5 (reference type) take the value of the first write after reset. Later writes leave those bits unchanged.
- R3: The prescale output is 1 when the range bit is 1 and the effective mode is 10 or 11. In every other case it is 64.
- R4: An accepted request for mode 10 keeps the effective mode unchanged, whatever the done input does, until the external-ready input is 1. The effective mode becomes 10 at the clock edge where ready is sampled high.
- R5: An accepted write of a mode other than 10 makes the block busy. The effective mode becomes the requested one at the edge where done is sampled high, and busy then clears. Mode-field writes made while busy leave bits 4:3 unchanged.
- R6: If the first write after reset carries mode 00 or 01, any later write with bit 4 set leaves the mode field unchanged until reset. Later writes of mode 00 or 01 are still taken.
- R7: Bits 2 (oscillator runs in stop) and 1 (loss-of-clock detect disable) take every written value. Bit 0 always reads 0.
- R8: While the hold (off) input is 1, done and ready are ignored, and both the stored mode and the effective mode stay unchanged.
- R9: Read bits 4:3 show the requested mode, and the effective-mode output separately shows the mode in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Register read value |
| ext_ready | input | 1 | External reference is stable |
| chg_done | input | 1 | Mode switch finished pulse |
| hold | input | 1 | Off state: freeze mode sequencing |
| gain_hi | output | 1 | High-gain oscillator select |
| range_hi | output | 1 | High frequency range select |
| ref_xtal | output | 1 | Crystal (1) or external clock (0) reference |
| mode_req | output | 2 | Requested clock mode |
| mode_eff | output | 2 | Effective clock mode |
| busy | output | 1 | Mode change incomplete |
| loop_prescale | output | 7 | Loop prescale factor (1 or 64) |
| stop_osc_en | output | 1 | Oscillator kept running in stop |
| lossclk_dis | output | 1 | Loss-of-clock detect disabled |

## Verification
The assertions take for granted that ready, done and hold are never unknown once reset is released. They also assume that done and ready may arrive in any cycle, including cycles where nothing is pending, and that the block must then ignore them. The directed stimulus keeps each input at a known level from time zero. It gives done as single-cycle pulses driven on the falling edge, sometimes while a mode-10 request is pending and sometimes under hold, so that the cases where those inputs must be ignored are also exercised.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
   typedef enum logic [1:0] {
      MODE_SELF = 2'b00,
      MODE_INT  = 2'b01,
      MODE_BYP  = 2'b10,
      MODE_EXT  = 2'b11
   } clk_mode_e;

   localparam int BYTE_W    = 8;
   localparam int POS_GAIN  = 7;
   localparam int POS_RANGE = 6;
   localparam int POS_REF   = 5;
   localparam int POS_MODE  = 3;
   localparam int POS_STOP  = 2;
   localparam int POS_LOSS  = 1;
   localparam int N_ONCE    = 3;
endpackage

// File: rtl/clkmode_once.sv
module clkmode_once #(
   parameter int  W      = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q      <= RST_VAL;
         lock_q <= 1'b0;
      end else if (wr && !lock_q) begin
         q      <= d;
         lock_q <= 1'b1;
      end
   end

   p_locked_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(q));
endmodule

// File: rtl/clkmode_seq.sv
module clkmode_seq
   import clkmode_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [1:0] wr_mode,
   input  logic       ext_ready,
   input  logic       done,
   input  logic       hold,
   output logic [1:0] req,
   output logic [1:0] eff,
   output logic       busy
);
   logic first_q, forbid_q, accept;

   assign accept = wr && !busy && !(forbid_q && wr_mode[1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q  <= 1'b0;
         forbid_q <= 1'b0;
         req      <= MODE_SELF;
         eff      <= MODE_SELF;
         busy     <= 1'b0;
      end else begin
         if (wr && !first_q) begin
            first_q  <= 1'b1;
            forbid_q <= !wr_mode[1];
         end
         if (accept) begin
            req  <= wr_mode;
            busy <= 1'b1;
         end else if (busy && !hold) begin
            if (req == MODE_BYP) begin
               if (ext_ready) begin
                  eff  <= MODE_BYP;
                  busy <= 1'b0;
               end
            end else if (done) begin
               eff  <= req;
               busy <= 1'b0;
            end
         end
      end
   end

   p_busy_blocks_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(req));
   p_eff_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !ext_ready) |=> $stable(eff));
   p_bypass_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (eff != MODE_BYP && !ext_ready) |=> eff != MODE_BYP);
   p_ext_lockout_r6: assert property (@(posedge clk) disable iff (!rst_n)
      forbid_q |-> !req[1]);
   p_hold_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !wr) |=> ($stable(eff) && $stable(req)));
endmodule

// File: rtl/clkmode_ctl.sv
module clkmode_ctl
   import clkmode_pkg::*;
#(
   parameter int PRESCALE_LO = 64,
   parameter int PRESCALE_HI = 1,
   localparam int PS_W = $clog2(PRESCALE_LO + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [7:0]      wr_data,
   output logic [7:0]      rd_data,
   input  logic            ext_ready,
   input  logic            chg_done,
   input  logic            hold,
   output logic            gain_hi,
   output logic            range_hi,
   output logic            ref_xtal,
   output logic [1:0]      mode_req,
   output logic [1:0]      mode_eff,
   output logic            busy,
   output logic [PS_W-1:0] loop_prescale,
   output logic            stop_osc_en,
   output logic            lossclk_dis
);
   localparam int ONCE_POS [N_ONCE] = '{POS_GAIN, POS_RANGE, POS_REF};
   localparam logic [N_ONCE-1:0] ONCE_RST = 3'b010;

   if (PRESCALE_LO < 1 || PRESCALE_HI < 1 || PRESCALE_HI > PRESCALE_LO) begin : g_bad_cfg
      $error("clkmode_ctl: prescale parameters out of range");
   end

   logic [N_ONCE-1:0] once_q;

   for (genvar i = 0; i < N_ONCE; i++) begin : g_once
      clkmode_once #(.W(1), .RST_VAL(ONCE_RST[N_ONCE-1-i])) u_once (
         .clk  (clk),
         .rst_n(rst_n),
         .wr   (wr_en),
         .d    (wr_data[ONCE_POS[i]]),
         .q    (once_q[N_ONCE-1-i])
      );
   end

   assign gain_hi  = once_q[2];
   assign range_hi = once_q[1];
   assign ref_xtal = once_q[0];

   clkmode_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_en),
      .wr_mode  (wr_data[POS_MODE +: 2]),
      .ext_ready(ext_ready),
      .done     (chg_done),
      .hold     (hold),
      .req      (mode_req),
      .eff      (mode_eff),
      .busy     (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_osc_en <= 1'b1;
         lossclk_dis <= 1'b0;
      end else if (wr_en) begin
         stop_osc_en <= wr_data[POS_STOP];
         lossclk_dis <= wr_data[POS_LOSS];
      end
   end

   always_comb begin
      if (range_hi && mode_eff[1]) loop_prescale = PS_W'(PRESCALE_HI);
      else                         loop_prescale = PS_W'(PRESCALE_LO);
   end

   assign rd_data = {gain_hi, range_hi, ref_xtal, mode_req, stop_osc_en, lossclk_dis, 1'b0};

   p_fast_prescale_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_prescale == PS_W'(PRESCALE_HI)) |-> (range_hi && mode_eff[1]));
   p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !rd_data[0]);
endmodule

// File: tb/clkmode_ctl_bench.sv
module clkmode_ctl_bench;
   logic       clk = 0, rst_n = 0, wr_en = 0, ext_ready = 0, chg_done = 0, hold = 0;
   logic [7:0] wr_data = 0, rd_data;
   logic       gain_hi, range_hi, ref_xtal, busy, stop_osc_en, lossclk_dis;
   logic [1:0] mode_req, mode_eff;
   logic [6:0] loop_prescale;
   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   clkmode_ctl u_clkmode_ctl (.*);

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; wr_en = 0; chg_done = 0; ext_ready = 0; hold = 0;
      @(negedge clk); rst_n = 1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] v);
      wr_en = 1; wr_data = v;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic pulse_done();
      chg_done = 1; @(negedge clk); chg_done = 0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 rd", rd_data, 8'h44);
      chk("R1 eff", mode_eff, 0);
      chk("R1 busy", busy, 0);
      chk("R1 prescale", loop_prescale, 64);
   endtask

   task automatic t_write_once();
      do_reset();
      wr(8'hBE);
      chk("R2 first write", rd_data, 8'hBE);
      chk("R5 busy after write", busy, 1);
      chk("R5 eff before done", mode_eff, 0);
      pulse_done();
      chk("R5 eff after done", mode_eff, 3);
      chk("R3 range0 ext prescale", loop_prescale, 64);
      wr(8'h58);
      chk("R2 R7 later write", rd_data, 8'hB8);
      chk("R2 gain held", gain_hi, 1);
   endtask

   task automatic t_ext_pending();
      do_reset();
      wr(8'h58);
      chk("R3 before done", loop_prescale, 64);
      pulse_done();
      chk("R3 range1 mode11", loop_prescale, 1);
      wr(8'h50);
      chk("R9 req shows 10", rd_data[4:3], 2);
      chk("R9 eff still 11", mode_eff, 3);
      pulse_done();
      chk("R4 done ignored while pending", mode_eff, 3);
      chk("R4 still busy", busy, 1);
      ext_ready = 1; @(negedge clk); ext_ready = 0;
      chk("R4 eff 10 after ready", mode_eff, 2);
      chk("R3 bypass range1", loop_prescale, 1);
      chk("R4 not busy", busy, 0);
   endtask

   task automatic t_busy();
      do_reset();
      wr(8'h48);
      wr(8'h40);
      chk("R5 write ignored while busy", rd_data[4:3], 1);
      pulse_done();
      chk("R5 eff 01", mode_eff, 1);
      chk("R3 internal prescale", loop_prescale, 64);
      wr(8'h40);
      chk("R5 write taken when idle", rd_data[4:3], 0);
   endtask

   task automatic t_lockout();
      do_reset();
      wr(8'h4C);
      pulse_done();
      wr(8'h5C);
      chk("R6 ext mode refused", rd_data, 8'h4C);
      chk("R6 not busy", busy, 0);
      wr(8'h44);
      chk("R6 internal mode taken", rd_data, 8'h44);
   endtask

   task automatic t_low_bits();
      do_reset();
      wr(8'h47);
      chk("R7 bits 2:1 and bit0", rd_data, 8'h46);
      pulse_done();
      wr(8'h40);
      chk("R7 cleared", rd_data[2:0], 0);
   endtask

   task automatic t_off();
      do_reset();
      wr(8'h48);
      hold = 1;
      pulse_done();
      chk("R8 eff held", mode_eff, 0);
      chk("R8 stored mode held", rd_data[4:3], 1);
      hold = 0;
      pulse_done();
      chk("R8 completes after hold", mode_eff, 1);
   endtask

   initial begin
      t_reset();
      t_write_once();
      t_ext_pending();
      t_busy();
      t_lockout();
      t_low_bits();
      t_off();
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule